// File: doc/BRIEF.md
# Address-Stable Automatic Sleep Detector

This block belongs to a clocked model of a parallel flash read port. It registers the address bus on every clock edge and compares it with the previous value. Each edge on which the address has not moved advances a stability counter. When the counter reaches the access time, the array data is captured into an output register and flagged valid. When the counter reaches the access time plus a fixed margin, the block raises a sleep flag. From then on, the captured word is held for the reader. Any change of address drops both flags and starts a fresh access. The block has no chip, write or output enable input, so sleep entry and exit follow the address alone.

The sequencer has three states:
- `ST_ACCESS`: an access is in progress and the output is not yet valid.
- `ST_VALID`: data has been captured and the margin is still being counted.
- `ST_SLEEP`: the array may power down and the output holds the captured word.

The transitions are:
- `ST_ACCESS` to `ST_VALID` on the edge that completes the access count. On this edge the latch loads.
- `ST_VALID` to `ST_SLEEP` on the edge that completes the access-plus-margin count.
- Any state to `ST_ACCESS` on an address change.
- `ST_SLEEP` stays in `ST_SLEEP` while the address holds.

The synchronous reset forces `ST_ACCESS`.

Top module: `asd_sleep_detect`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `data_valid`, `sleep`, `data_out` (to zero), the stability counter and the stored address (to zero) after that edge.
- R2: If `addr` differs from the value registered at the previous edge, `data_valid` and `sleep` are low after that edge, and the stability counter restarts from zero.
- R3: `data_valid` rises after exactly ACC_CYC further edges of unchanged address, following the edge that saw the change. On that same edge, `data_out` takes the `data_in` value present at that edge.
- R4: `sleep` rises after exactly ACC_CYC+MARGIN_CYC edges of unchanged address, following the change edge. `sleep` is never high without `data_valid`.
- R5: Once `data_valid` is high, `data_out` keeps its value whatever `data_in` does, as long as the address holds.
- R6: The stability counter stops at ACC_CYC+MARGIN_CYC and never wraps. An address held for many cycles keeps `sleep` and `data_valid` high and `data_out` unchanged.
- R7: An address that holds for fewer than ACC_CYC edges after its change edge never raises `data_valid` or `sleep`.
- R8: While an access is in progress (`data_valid` low), `data_out` keeps the previously captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Read address bus |
| data_in | input | DATA_W | Word delivered by the array for the current address |
| data_out | output | DATA_W | Captured read data |
| sleep | output | 1 | High when the array may enter low-power sleep |
| data_valid | output | 1 | High when `data_out` holds the word of the current address |

## Verification
An address change is seen on the rising edge after it is driven, and the flags are cleared right after that edge. `data_valid` and the capture follow ACC_CYC edges later, and `sleep` follows ACC_CYC+MARGIN_CYC edges later. With the defaults these are edges 7 and 10 counted from the change edge. The bench drives every input on a falling edge and pushes the expected `data_valid`, `sleep` and `data_out` for the coming rising edge into a queue. A monitor then compares them 2 ns after that edge, so every result is checked in the exact cycle it is due. Data words that change on each cycle of an access confirm that the capture happens on one edge only.

// File: rtl/asd_pkg.sv
package asd_pkg;

    typedef enum logic [1:0] {
        ST_ACCESS = 2'd0,
        ST_VALID  = 2'd1,
        ST_SLEEP  = 2'd2
    } asd_state_e;

endpackage

// File: rtl/asd_addr_watch.sv
module asd_addr_watch #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic              chg_o
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_i;
        end
    end

    assign chg_o    = (addr_i != addr_q);
    assign addr_q_o = addr_q;

endmodule

// File: rtl/asd_stab_cnt.sv
module asd_stab_cnt #(
    parameter int LIMIT = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt <= '0;
        end else if (cnt != CNT_TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign cnt_o = cnt;

endmodule

// File: rtl/asd_fsm.sv
module asd_fsm
    import asd_pkg::*;
#(
    parameter int ACC_CYC   = 7,
    parameter int SLEEP_CYC = 10,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chg_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             load_o,
    output logic             valid_o,
    output logic             sleep_o
);

    localparam logic [CNT_W-1:0] ACC_LAST   = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] SLEEP_LAST = CNT_W'(SLEEP_CYC - 1);

    asd_state_e state_q;
    asd_state_e state_d;

    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        if (chg_i) begin
            state_d = ST_ACCESS;
        end else begin
            unique case (state_q)
                ST_ACCESS: begin
                    if (cnt_i == ACC_LAST) begin
                        state_d = ST_VALID;
                        load_o  = 1'b1;
                    end
                end
                ST_VALID: begin
                    if (cnt_i == SLEEP_LAST) begin
                        state_d = ST_SLEEP;
                    end
                end
                ST_SLEEP: begin
                    state_d = ST_SLEEP;
                end
                default: begin
                    state_d = ST_ACCESS;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACCESS;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        valid_o = (state_q == ST_VALID) || (state_q == ST_SLEEP);
        sleep_o = (state_q == ST_SLEEP);
    end

endmodule

// File: rtl/asd_data_latch.sv
module asd_data_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load_i) begin
            held_q <= data_i;
        end
    end

    assign data_o = held_q;

endmodule

// File: rtl/asd_sleep_detect.sv
module asd_sleep_detect #(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int ACC_CYC    = 7,
    parameter int MARGIN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              sleep,
    output logic              data_valid
);

    localparam int SLEEP_CYC = ACC_CYC + MARGIN_CYC;
    localparam int CNT_W     = $clog2(SLEEP_CYC + 1);

    logic [ADDR_W-1:0] addr_q;
    logic              chg;
    logic [CNT_W-1:0]  cnt;
    logic              load;

    asd_addr_watch #(
        .ADDR_W (ADDR_W)
    ) u_watch (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (addr),
        .addr_q_o (addr_q),
        .chg_o    (chg)
    );

    asd_stab_cnt #(
        .LIMIT (SLEEP_CYC),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (chg),
        .cnt_o (cnt)
    );

    asd_fsm #(
        .ACC_CYC   (ACC_CYC),
        .SLEEP_CYC (SLEEP_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .chg_i   (chg),
        .cnt_i   (cnt),
        .load_o  (load),
        .valid_o (data_valid),
        .sleep_o (sleep)
    );

    asd_data_latch #(
        .DATA_W (DATA_W)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .data_i (data_in),
        .data_o (data_out)
    );

endmodule

// File: rtl/asd_sleep_detect_chk.sv
module asd_sleep_detect_chk #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int ACC_CYC   = 7,
    parameter int SLEEP_CYC = 10,
    parameter int CNT_W     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] addr_q,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] data_out,
    input logic              sleep,
    input logic              data_valid
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!data_valid && !sleep && cnt == '0 && data_out == '0));

    p_change_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (addr != addr_q) |=> (!data_valid && !sleep && cnt == '0));

    p_valid_on_time_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> (cnt == CNT_W'(ACC_CYC)));

    p_sleep_on_time_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep) |-> (cnt == CNT_W'(SLEEP_CYC)));

    p_sleep_implies_valid_r4: assert property (@(posedge clk) disable iff (rst)
        sleep |-> data_valid);

    p_hold_data_r5: assert property (@(posedge clk) disable iff (rst)
        (!$rose(data_valid) && !$past(rst)) |-> $stable(data_out));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(SLEEP_CYC));

endmodule

bind asd_sleep_detect asd_sleep_detect_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ACC_CYC   (ACC_CYC),
    .SLEEP_CYC (SLEEP_CYC),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .addr_q     (addr_q),
    .cnt        (cnt),
    .data_out   (data_out),
    .sleep      (sleep),
    .data_valid (data_valid)
);

// File: tb/asd_sleep_detect_tb.sv
module asd_sleep_detect_tb;

    localparam int AW  = 20;
    localparam int DW  = 16;
    localparam int ACC = 7;
    localparam int MRG = 3;
    localparam int SLP = ACC + MRG;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] data_out;
    logic          sleep;
    logic          data_valid;

    always #5 clk = ~clk;

    asd_sleep_detect #(
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .ACC_CYC    (ACC),
        .MARGIN_CYC (MRG)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .data_in    (din),
        .data_out   (data_out),
        .sleep      (sleep),
        .data_valid (data_valid)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic          qv[$];
    logic          qs[$];
    logic [DW-1:0] qd[$];
    string         qt[$];

    logic [AW-1:0] m_aq  = '0;
    int            m_cnt = 0;
    logic          m_v   = 1'b0;
    logic          m_s   = 1'b0;
    logic [DW-1:0] m_d   = '0;

    function automatic logic [DW-1:0] patt(input logic [AW-1:0] a);
        return a[DW-1:0] ^ 16'h5A3C;
    endfunction

    task automatic step(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic r, input string tag_in);
        string tag;
        @(negedge clk);
        addr = a;
        din  = d;
        rst  = r;
        if (r) begin
            m_aq = '0; m_cnt = 0; m_v = 1'b0; m_s = 1'b0; m_d = '0;
            tag = "R1";
        end else if (a != m_aq) begin
            m_aq = a; m_cnt = 0; m_v = 1'b0; m_s = 1'b0;
            tag = "R2";
        end else begin
            if (m_cnt < SLP) m_cnt++;
            tag = m_v ? (m_s ? "R6" : "R5") : "R8";
            if (!m_v && m_cnt == ACC) begin
                m_v = 1'b1; m_d = d; tag = "R3";
            end
            if (!m_s && m_cnt == SLP) begin
                m_s = 1'b1; tag = "R4";
            end
        end
        if (tag_in != "") tag = tag_in;
        qv.push_back(m_v);
        qs.push_back(m_s);
        qd.push_back(m_d);
        qt.push_back(tag);
    endtask

    always @(posedge clk) begin : monitor
        logic          ev;
        logic          es;
        logic [DW-1:0] ed;
        string         et;
        #2;
        if (qv.size() > 0) begin
            ev = qv.pop_front();
            es = qs.pop_front();
            ed = qd.pop_front();
            et = qt.pop_front();
            total++;
            if (data_valid !== ev || sleep !== es || data_out !== ed) begin
                bad++;
                $display("FAIL %s: valid/sleep/data got %b/%b/%h expected %b/%b/%h",
                         et, data_valid, sleep, data_out, ev, es, ed);
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            finish_run();
        end
    end

    initial begin : driver
        // R1: reset state with a nonzero address present
        for (int i = 0; i < 3; i++) step(20'h00123, 16'hFFFF, 1'b1, "");

        // R2 R3 R4 R5 R6: long hold, data_in scrambled after capture
        for (int i = 0; i < 25; i++)
            step(20'h1A2B3, (i >= 8) ? ~patt(20'h1A2B3) ^ DW'(i) : patt(20'h1A2B3), 1'b0, "");

        // R3: data_in changes every cycle, capture must take the word of edge ACC
        for (int i = 0; i < 9; i++)
            step(20'h04444, patt(20'h04444) + DW'(i), 1'b0, "");

        // R7: short windows never raise the flags; R8: old word kept
        for (int i = 0; i < 4; i++) step(20'h00010, patt(20'h00010), 1'b0, (i == 0) ? "" : "R7");
        for (int i = 0; i < 5; i++) step(20'h00020, patt(20'h00020), 1'b0, (i == 0) ? "" : "R7");
        for (int i = 0; i < 6; i++) step(20'h00030, patt(20'h00030), 1'b0, (i == 0) ? "" : "R7");

        // full access after the short ones, then a long sleep (R6)
        for (int i = 0; i < 30; i++) step(20'hFFFFF, patt(20'hFFFFF) ^ DW'(i * 3), 1'b0, "");

        // R1: reset while asleep, then a new access from cleared state
        step(20'hFFFFF, 16'h1111, 1'b1, "");
        for (int i = 0; i < 12; i++) step(20'h0BEEF, patt(20'h0BEEF), 1'b0, "");

        // R2: single-bit address change while asleep
        for (int i = 0; i < 12; i++) step(20'h0BEEE, patt(20'h0BEEE), 1'b0, "");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule